// File: doc/BRIEF.md
# Flash High-Voltage Enable Protection Gate

This block sits between the flash control bits and the high-voltage switch of an on-chip flash. It decides whether a program or erase request may turn on the high-voltage enable. An 8-bit protect value, mirrored from a byte stored in the flash array, marks the lowest address of a locked region. That region always extends to the top of the 16-bit address space. The gate compares each target address against this region. It also checks that the control bits arrive in the required order: an operation is armed, the protect value is read, and only then is the high-voltage enable requested.

A test-voltage input opens the whole array when it is asserted. The protect byte has no special guard. A granted erase that covers its page, or a granted mass erase, returns the mirrored value to the erased state ($FF). Any refused request raises a sticky violation flag. The flag stays set until both operation bits are dropped.

Top module: `flash_hv_gate`

## Requirements
- R1: With protect value P other than $FF and the override low, a target address A is locked exactly when A >= P*256 (P in bits 15..8, low byte zero). A program or single-page erase of a locked address is refused with violation set; an unlocked address is granted.
- R2: With P = $FF, a correctly sequenced program or page erase is granted at any address.
- R3: With P = $00 and the override low, every program and erase request is refused.
- R4: A high-voltage request is granted only if a protect-read strobe was seen after the operation was armed. A request without such a read, including one after a read that came before arming, is refused and sets violation.
- R5: While testOverride is high, a correctly sequenced request is granted whatever P is.
- R6: A mass erase (eraseKind = 1) is refused unless P = $FF or the override is high. A granted mass erase sets protValue to $FF on the cycle after the grant edge.
- R7: A granted page erase (eraseKind = 0) whose 64-byte page contains address $FF7E sets protValue to $FF. A granted erase of any other page, and any program, leaves protValue unchanged.
- R8: protValue takes protInit while rstN is low and ignores protInit afterwards.
- R9: When pgmBit and eraseBit are both low, hvenGrant and violation are both low after the next clock edge.
- R10: When pgmBit and eraseBit are both high, hvenGrant is low and violation is high after the next clock edge.
- R11: hvenGrant is registered. It rises on the edge that samples an accepted hvenReq and stays high while the same single operation bit remains set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; protect value reloads while low |
| protInit | input | 8 | Stored protect byte from the flash array |
| pgmBit | input | 1 | Program operation armed (level) |
| eraseBit | input | 1 | Erase operation armed (level) |
| eraseKind | input | 1 | 1 = mass erase, 0 = single page erase |
| hvenReq | input | 1 | One-cycle request to set the high-voltage enable |
| protRead | input | 1 | One-cycle strobe: the protect value was read |
| tgtAddr | input | 16 | Target flash address |
| testOverride | input | 1 | Test voltage present; bypasses all protection |
| hvenGrant | output | 1 | High-voltage enable granted |
| violation | output | 1 | Sticky flag for a refused request or illegal bit combination |
| protValue | output | 8 | Current protect value |

## Verification
The assertions rely on a few properties of the inputs. Operation bits are levels that stay put from arming until the operation is dropped. hvenReq and protRead are single-cycle pulses. The protect value can change only through reset or a granted erase. The stimulus drops both operation bits between trials. It drives each strobe for exactly one cycle, and it changes tgtAddr and eraseKind only while no operation is armed. This keeps the address the grant was decided on equal to the address the erase commits on.

// File: rtl/fg_pkg.sv
package fg_pkg;
  // sequence tracker states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_READY = 2'd2,
    ST_HIGH  = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic pageCommit;
    logic massCommit;
  } dpStrobe_t;

  localparam int unsigned PROT_W = 8;
endpackage

// File: rtl/fg_datapath.sv
module fg_datapath
  import fg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_BITS = 6,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 16'hFF7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PROT_W-1:0] protInit,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic              testOverride,
  input  dpStrobe_t         strobe,
  output logic [PROT_W-1:0] protValue,
  output logic              addrLocked,
  output logic              massLocked
);
  localparam int unsigned LOW_W  = ADDR_W - PROT_W;
  localparam int unsigned PAGE_W = ADDR_W - PAGE_BITS;
  localparam logic [PAGE_W-1:0] PROT_PAGE = PROT_ADDR[ADDR_W-1:PAGE_BITS];
  localparam logic [PROT_W-1:0] ERASED = '1;

  logic [ADDR_W-1:0] lockStart;
  logic              protActive;
  logic              pageHitsProt;

  assign lockStart    = {protValue, {LOW_W{1'b0}}};
  assign protActive   = (protValue != ERASED) && !testOverride;
  assign addrLocked   = protActive && (tgtAddr >= lockStart);
  assign massLocked   = protActive;
  assign pageHitsProt = (tgtAddr[ADDR_W-1:PAGE_BITS] == PROT_PAGE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protValue <= protInit;
    end else if (strobe.massCommit || (strobe.pageCommit && pageHitsProt)) begin
      protValue <= ERASED;
    end
  end
endmodule

// File: rtl/fg_ctrl.sv
module fg_ctrl
  import fg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pgmBit,
  input  logic      eraseBit,
  input  logic      eraseKind,
  input  logic      hvenReq,
  input  logic      protRead,
  input  logic      addrLocked,
  input  logic      massLocked,
  output logic      hvenGrant,
  output logic      violation,
  output dpStrobe_t strobe
);
  seqState_t state, nState;
  logic      armedErase;
  logic      nGrant, nViol;
  logic      bothLow, bothHigh, opChanged, locked;

  assign bothLow   = !pgmBit && !eraseBit;
  assign bothHigh  = pgmBit && eraseBit;
  assign opChanged = (state == ST_IDLE) || (armedErase != eraseBit);
  assign locked    = (eraseBit && eraseKind) ? massLocked : addrLocked;

  always_comb begin
    nState = state;
    nGrant = hvenGrant;
    nViol  = violation;
    strobe = '0;
    if (bothLow) begin
      nState = ST_IDLE;
      nGrant = 1'b0;
      nViol  = 1'b0;
    end else if (bothHigh) begin
      nState = ST_IDLE;
      nGrant = 1'b0;
      nViol  = 1'b1;
    end else if (opChanged) begin
      nState = ST_ARMED;
      nGrant = 1'b0;
      if (hvenReq) nViol = 1'b1;
    end else begin
      unique case (state)
        ST_ARMED: begin
          if (hvenReq) nViol = 1'b1;
          else if (protRead) nState = ST_READY;
        end
        ST_READY: begin
          if (hvenReq) begin
            if (locked) begin
              nViol = 1'b1;
            end else begin
              nState = ST_HIGH;
              nGrant = 1'b1;
              strobe.pageCommit = eraseBit && !eraseKind;
              strobe.massCommit = eraseBit && eraseKind;
            end
          end
        end
        ST_HIGH: nGrant = 1'b1;
        default: nState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      armedErase <= 1'b0;
      hvenGrant  <= 1'b0;
      violation  <= 1'b0;
    end else begin
      state      <= nState;
      armedErase <= eraseBit;
      hvenGrant  <= nGrant;
      violation  <= nViol;
    end
  end
endmodule

// File: rtl/flash_hv_gate.sv
module flash_hv_gate
  import fg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_BITS = 6,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 16'hFF7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        protInit,
  input  logic              pgmBit,
  input  logic              eraseBit,
  input  logic              eraseKind,
  input  logic              hvenReq,
  input  logic              protRead,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic              testOverride,
  output logic              hvenGrant,
  output logic              violation,
  output logic [7:0]        protValue
);
  dpStrobe_t strobe;
  logic      addrLocked, massLocked;

  fg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pgmBit(pgmBit), .eraseBit(eraseBit),
    .eraseKind(eraseKind), .hvenReq(hvenReq), .protRead(protRead),
    .addrLocked(addrLocked), .massLocked(massLocked),
    .hvenGrant(hvenGrant), .violation(violation), .strobe(strobe)
  );

  fg_datapath #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .PROT_ADDR(PROT_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .protInit(protInit), .tgtAddr(tgtAddr),
    .testOverride(testOverride), .strobe(strobe), .protValue(protValue),
    .addrLocked(addrLocked), .massLocked(massLocked)
  );
endmodule

// File: rtl/fg_checker.sv
module fg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pgmBit,
  input logic       eraseBit,
  input logic       hvenReq,
  input logic       testOverride,
  input logic [7:0] protValue,
  input logic       hvenGrant,
  input logic       violation
);
  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!pgmBit && !eraseBit) |=> (!hvenGrant && !violation)); // R9

  AST_BOTH_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (pgmBit && eraseBit) |=> (!hvenGrant && violation)); // R10

  AST_ZERO_LOCKS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (!hvenGrant && protValue == 8'h00 && !testOverride) |=> !hvenGrant); // R3

  AST_ERASE_ONLY_TO_FF: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && protValue != $past(protValue)) |-> protValue == 8'hFF); // R7

  AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $rose(hvenGrant)) |-> $past(hvenReq)); // R11

  AST_GRANT_SINGLE_OP: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && hvenGrant) |-> $past(pgmBit ^ eraseBit)); // R10
endmodule

bind flash_hv_gate fg_checker u_chk (
  .clk(clk), .rstN(rstN), .pgmBit(pgmBit), .eraseBit(eraseBit),
  .hvenReq(hvenReq), .testOverride(testOverride), .protValue(protValue),
  .hvenGrant(hvenGrant), .violation(violation)
);

// File: tb/sim_flash_hv_gate.sv
`timescale 1ns/1ps
module sim_flash_hv_gate;
  logic        clk = 1'b0;
  logic        rstN, pgmBit, eraseBit, eraseKind, hvenReq, protRead, testOverride;
  logic [7:0]  protInit;
  logic [15:0] tgtAddr;
  logic        hvenGrant, violation;
  logic [7:0]  protValue;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 1'b0;

  always #5 clk = ~clk;

  flash_hv_gate u0 (
    .clk(clk), .rstN(rstN), .protInit(protInit), .pgmBit(pgmBit),
    .eraseBit(eraseBit), .eraseKind(eraseKind), .hvenReq(hvenReq),
    .protRead(protRead), .tgtAddr(tgtAddr), .testOverride(testOverride),
    .hvenGrant(hvenGrant), .violation(violation), .protValue(protValue)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expGrant(logic [7:0] p, logic [15:0] a, bit isErase,
                                  bit mass, bit ov, bit didRead);
    if (!didRead)        return 1'b0;
    if (ov)              return 1'b1;
    if (p == 8'hFF)      return 1'b1;
    if (isErase && mass) return 1'b0;
    return a < {p, 8'h00};
  endfunction

  function automatic logic [7:0] expProt(logic [7:0] p, logic [15:0] a, bit isErase,
                                         bit mass, bit granted);
    if (granted && isErase && (mass || a[15:6] == 10'h3FD)) return 8'hFF;
    return p;
  endfunction

  task automatic doReset(logic [7:0] p);
    rstN = 1'b0; protInit = p;
    pgmBit = 0; eraseBit = 0; eraseKind = 0; hvenReq = 0; protRead = 0;
    testOverride = 0; tgtAddr = '0;
    tick(); tick();
    rstN = 1'b1;
    protInit = ~p;
    tick();
  endtask

  // one complete trial; returns nothing, checks grant, flag and protect value
  task automatic trial(string tag, logic [7:0] p, logic [15:0] a, bit isErase,
                       bit mass, bit ov, bit didRead, bit readFirst);
    bit g;
    logic [7:0] cur;
    cur = protValue;
    tgtAddr = a; eraseKind = mass; testOverride = ov;
    if (readFirst) begin protRead = 1; tick(); protRead = 0; end
    pgmBit = !isErase; eraseBit = isErase;
    tick();
    if (didRead) begin protRead = 1; tick(); protRead = 0; end
    hvenReq = 1; tick(); hvenReq = 0;
    g = expGrant(cur, a, isErase, mass, ov, didRead);
    check({tag, " grant"}, hvenGrant, g);
    check({tag, " violation"}, violation, !g);
    check({tag, " protValue"}, protValue, expProt(cur, a, isErase, mass, g));
    if (g) begin
      tick(); tick();
      check({tag, " R11 grant held"}, hvenGrant, 1);
    end
    pgmBit = 0; eraseBit = 0;
    tick();
    check({tag, " R9 grant dropped"}, hvenGrant, 0);
    check({tag, " R9 flag cleared"}, violation, 0);
    testOverride = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R8: reset load and later independence from protInit
    doReset(8'h80);
    check("R8 reset load", protValue, 8'h80);
    check("R9 reset grant", hvenGrant, 0);
    check("R9 reset flag", violation, 0);
    tick(); tick();
    check("R8 protInit ignored", protValue, 8'h80);

    // R1 boundary around start $8000
    trial("R1 below start", 8'h80, 16'h7FFF, 0, 0, 0, 1, 0);
    trial("R1 at start",    8'h80, 16'h8000, 0, 0, 0, 1, 0);
    trial("R1 page erase locked", 8'h80, 16'hC000, 1, 0, 0, 1, 0);
    trial("R7 page erase other page", 8'h80, 16'h1000, 1, 0, 0, 1, 0);
    trial("R7 prot page locked", 8'h80, 16'hFF7E, 1, 0, 0, 1, 0);
    // R4: missing read, and read before arming
    trial("R4 no read", 8'h80, 16'h0100, 0, 0, 0, 0, 0);
    trial("R4 read before arm", 8'h80, 16'h0100, 0, 0, 0, 0, 1);
    // R6 mass erase locked
    trial("R6 mass locked", 8'h80, 16'h0000, 1, 1, 0, 1, 0);
    // R5 override, R7 erase of protect page under override
    trial("R5 override program", 8'h80, 16'hFFFF, 0, 0, 1, 1, 0);
    trial("R7 override page erase", 8'h80, 16'hFF40, 1, 0, 1, 1, 0);
    check("R7 value erased", protValue, 8'hFF);

    // R3 all zeros
    doReset(8'h00);
    trial("R3 zero addr0", 8'h00, 16'h0000, 0, 0, 0, 1, 0);
    trial("R3 zero erase", 8'h00, 16'h2345, 1, 0, 0, 1, 0);
    // R6 mass erase with override
    trial("R6 mass override", 8'h00, 16'h0000, 1, 1, 1, 1, 0);
    check("R6 value erased", protValue, 8'hFF);

    // R2 fully open
    doReset(8'hFF);
    trial("R2 open top", 8'hFF, 16'hFFFF, 0, 0, 0, 1, 0);
    trial("R2 mass open", 8'hFF, 16'h0000, 1, 1, 0, 1, 0);

    // R10 both bits together
    doReset(8'hFF);
    pgmBit = 1; eraseBit = 1; tick();
    check("R10 both grant", hvenGrant, 0);
    check("R10 both flag", violation, 1);
    eraseBit = 0; tick();
    check("R9 flag sticky with one op", violation, 1);
    pgmBit = 0; tick();
    check("R9 flag cleared", violation, 0);

    // constrained random trials
    for (int i = 0; i < 200; i++) begin
      logic [7:0]  p;
      logic [15:0] a;
      int sel;
      sel = $urandom % 4;
      p = (sel == 0) ? 8'hFF : (sel == 1) ? 8'h00 : 8'($urandom);
      a = ($urandom % 8 == 0) ? 16'hFF7E : 16'($urandom);
      doReset(p);
      trial("R1 random", p, a, bit'($urandom % 2), bit'($urandom % 4 == 0),
            bit'($urandom % 8 == 0), bit'($urandom % 8 != 0), 1'b0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule